// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block holds the stack pointer of a small processor whose stack sits in data SRAM and grows toward lower addresses. The pointer always names the next free byte below the stack contents. Four command strobes move it: a single-byte push or pop moves it by one, and a return-address push (call or interrupt entry) or a return-address pop (return or return from interrupt) moves it by two. For every command the block also presents the SRAM byte addresses that the data path must use in the same cycle. A push writes at the current pointer and then moves down. A pop moves up first and then reads.

Software reaches the pointer as two byte-wide I/O registers: the upper byte sits at I/O address 0x3E and the lower byte at 0x3D. Both bytes can be read and written. After reset the pointer holds the last internal SRAM address, which is a parameter. A parameter also sets how many low-order pointer bits exist. The upper bits that do not exist always read as zero, and all pointer arithmetic wraps within the bits that do exist.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and after it is released, the pointer equals the parameter RAM_END (default 0x08FF), masked to the implemented bits.
- R2: A single-byte push presents the current pointer on stk_addr_lo and on stk_addr_hi. The pointer is one lower on the next cycle.
- R3: A single-byte pop presents pointer+1 on stk_addr_lo and on stk_addr_hi. The pointer is one higher on the next cycle.
- R4: A return-address push presents the current pointer on stk_addr_lo, which receives the low byte of the address, and pointer-1 on stk_addr_hi, which receives the high byte. The pointer is two lower on the next cycle.
- R5: A return-address pop presents pointer+2 on stk_addr_lo, which holds the low byte, and pointer+1 on stk_addr_hi, which holds the high byte. The pointer is two higher on the next cycle.
- R6: io_rdata is combinational. It returns pointer bits 15..8 when io_addr is 0x3E, bits 7..0 when io_addr is 0x3D, and 0 for any other address.
- R7: An io_wr to 0x3E replaces bits 15..8 of the pointer on the next cycle, and an io_wr to 0x3D replaces bits 7..0. An io_wr to any other address leaves the pointer unchanged.
- R8: Only the low IMPL_W bits of the pointer exist (default 12). The other bits always read as 0, and any value written to them is discarded. Increments and decrements wrap modulo 2^IMPL_W, on the pointer and on both address outputs.
- R9: When an I/O write to 0x3E or 0x3D and a stack command fall in the same cycle, the write sets the pointer and the command does not move it. The command's addresses are still presented.
- R10: When several commands are asserted together, only one takes effect. The order from highest to lowest priority is return-address push, return-address pop, single-byte push, single-byte pop.
- R11: With no command and no pointer write, the pointer holds its value and both address outputs equal the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_byte | input | 1 | Single-byte push command |
| pop_byte | input | 1 | Single-byte pop command |
| push_ret | input | 1 | Return-address push command |
| pop_ret | input | 1 | Return-address pop command |
| io_addr | input | IO_AW (6) | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| sp | output | SP_W (16) | Current stack pointer |
| stk_addr_lo | output | SP_W (16) | SRAM address of the single byte, or of the low byte of a return address |
| stk_addr_hi | output | SP_W (16) | SRAM address of the high byte of a return address |

## Verification
The case that needs care is a software write to one pointer byte in the same cycle as a stack command. The bench provokes it directly, with an I/O write to 0x3E or 0x3D issued together with a push or pop. It also lets the case arise at random during a long mixed sequence. The cycle-accurate reference model in the bench decides the outcome: the written byte lands, the other byte keeps its old value, and the command's addresses still appear. The model is compared against the pointer, both addresses and the read data on every clock. The same comparison covers several commands asserted together and wrap-around at address 0 and at the top of the implemented range.

// File: rtl/stack_ptr_unit_pkg.sv
package stack_ptr_unit_pkg;

   // Resolved stack operation for one cycle
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_PUSH1 = 3'd1,
      OP_POP1  = 3'd2,
      OP_PUSH2 = 3'd3,
      OP_POP2  = 3'd4
   } stk_op_e;

   // Raw command strobes as they arrive
   typedef struct packed {
      logic push_ret;
      logic pop_ret;
      logic push_byte;
      logic pop_byte;
   } stk_cmd_t;

endpackage

// File: rtl/stk_op_arb.sv
module stk_op_arb
   import stack_ptr_unit_pkg::*;
(
   input  stk_cmd_t cmd,
   output stk_op_e  op
);

   // Fixed priority: return push, return pop, byte push, byte pop
   always_comb begin
      if (cmd.push_ret)       op = OP_PUSH2;
      else if (cmd.pop_ret)   op = OP_POP2;
      else if (cmd.push_byte) op = OP_PUSH1;
      else if (cmd.pop_byte)  op = OP_POP1;
      else                    op = OP_IDLE;
   end

endmodule

// File: rtl/stk_fit.sv
module stk_fit #(
   parameter int SP_W   = 16,
   parameter int IMPL_W = 12
) (
   input  logic [SP_W-1:0] raw,
   output logic [SP_W-1:0] fitted
);

   generate
      if (IMPL_W < SP_W) begin : g_trim
         assign fitted = {{(SP_W-IMPL_W){1'b0}}, raw[IMPL_W-1:0]};
      end else begin : g_full
         assign fitted = raw;
      end
   endgenerate

endmodule

// File: rtl/stk_step.sv
module stk_step
   import stack_ptr_unit_pkg::*;
#(
   parameter int SP_W = 16
) (
   input  logic [SP_W-1:0] cur,
   input  stk_op_e         op,
   output logic [SP_W-1:0] nxt,
   output logic [SP_W-1:0] addr_lo,
   output logic [SP_W-1:0] addr_hi
);

   logic [SP_W-1:0] up1, up2, dn1, dn2;

   assign up1 = cur + SP_W'(1);
   assign up2 = cur + SP_W'(2);
   assign dn1 = cur - SP_W'(1);
   assign dn2 = cur - SP_W'(2);

   always_comb begin
      case (op)
         OP_PUSH1: begin nxt = dn1; addr_lo = cur; addr_hi = cur; end
         OP_PUSH2: begin nxt = dn2; addr_lo = cur; addr_hi = dn1; end
         OP_POP1:  begin nxt = up1; addr_lo = up1; addr_hi = up1; end
         OP_POP2:  begin nxt = up2; addr_lo = up2; addr_hi = up1; end
         default:  begin nxt = cur; addr_lo = cur; addr_hi = cur; end
      endcase
   end

endmodule

// File: rtl/stk_io_port.sv
module stk_io_port #(
   parameter int                SP_W     = 16,
   parameter int                IO_AW    = 6,
   parameter logic [IO_AW-1:0]  SPH_ADDR = 6'h3E,
   parameter logic [IO_AW-1:0]  SPL_ADDR = 6'h3D
) (
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic [7:0]       io_wdata,
   input  logic [SP_W-1:0]  cur,
   output logic [7:0]       io_rdata,
   output logic             wr_hit,
   output logic [SP_W-1:0]  wr_val
);

   logic sel_hi, sel_lo;

   assign sel_hi = (io_addr == SPH_ADDR);
   assign sel_lo = (io_addr == SPL_ADDR);
   assign wr_hit = io_wr && (sel_hi || sel_lo);

   always_comb begin
      if (sel_hi)      io_rdata = cur[15:8];
      else if (sel_lo) io_rdata = cur[7:0];
      else             io_rdata = 8'h00;
   end

   always_comb begin
      wr_val = cur;
      if (sel_hi) wr_val[15:8] = io_wdata;
      else        wr_val[7:0]  = io_wdata;
   end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import stack_ptr_unit_pkg::*;
#(
   parameter int                SP_W     = 16,
   parameter int                IMPL_W   = 12,
   parameter logic [15:0]       RAM_END  = 16'h08FF,
   parameter int                IO_AW    = 6,
   parameter logic [IO_AW-1:0]  SPH_ADDR = 6'h3E,
   parameter logic [IO_AW-1:0]  SPL_ADDR = 6'h3D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_byte,
   input  logic             pop_byte,
   input  logic             push_ret,
   input  logic             pop_ret,
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic [7:0]       io_wdata,
   output logic [7:0]       io_rdata,
   output logic [SP_W-1:0]  sp,
   output logic [SP_W-1:0]  stk_addr_lo,
   output logic [SP_W-1:0]  stk_addr_hi
);

   localparam int              N_FIT     = 4;
   localparam logic [SP_W:0]   IMPL_TOP  = (SP_W+1)'(1) << IMPL_W;
   localparam logic [SP_W-1:0] IMPL_MASK = SP_W'(IMPL_TOP - 1'b1);
   localparam logic [SP_W-1:0] RST_VAL   = SP_W'(RAM_END) & IMPL_MASK;

   // Elaboration-time parameter checks
   generate
      if (SP_W != 16) begin : g_bad_width
         $error("stack_ptr_unit: SP_W must be 16 (two I/O bytes)");
      end
      if (IMPL_W < 8 || IMPL_W > SP_W) begin : g_bad_impl
         $error("stack_ptr_unit: IMPL_W must lie in 8..SP_W");
      end
      if ((SP_W'(RAM_END) & ~IMPL_MASK) != '0) begin : g_bad_end
         $error("stack_ptr_unit: RAM_END exceeds implemented bits");
      end
      if (SPH_ADDR == SPL_ADDR) begin : g_bad_io
         $error("stack_ptr_unit: I/O byte addresses must differ");
      end
   endgenerate

   stk_cmd_t        cmd;
   stk_op_e         op;
   logic [SP_W-1:0] sp_q, sp_d;
   logic            wr_hit;
   logic [SP_W-1:0] raw_v [N_FIT];
   logic [SP_W-1:0] fit_v [N_FIT];

   assign cmd = '{push_ret: push_ret, pop_ret: pop_ret,
                  push_byte: push_byte, pop_byte: pop_byte};

   stk_op_arb u_arb (
      .cmd (cmd),
      .op  (op)
   );

   stk_step #(.SP_W(SP_W)) u_step (
      .cur     (sp_q),
      .op      (op),
      .nxt     (raw_v[0]),
      .addr_lo (raw_v[1]),
      .addr_hi (raw_v[2])
   );

   stk_io_port #(
      .SP_W(SP_W), .IO_AW(IO_AW), .SPH_ADDR(SPH_ADDR), .SPL_ADDR(SPL_ADDR)
   ) u_io (
      .io_addr  (io_addr),
      .io_wr    (io_wr),
      .io_wdata (io_wdata),
      .cur      (sp_q),
      .io_rdata (io_rdata),
      .wr_hit   (wr_hit),
      .wr_val   (raw_v[3])
   );

   // Trim every derived value to the implemented pointer bits
   generate
      for (genvar gi = 0; gi < N_FIT; gi++) begin : g_fit
         stk_fit #(.SP_W(SP_W), .IMPL_W(IMPL_W)) u_fit (
            .raw    (raw_v[gi]),
            .fitted (fit_v[gi])
         );
      end
   endgenerate

   // A software write outranks the stack command of the same cycle
   assign sp_d = wr_hit ? fit_v[3] : fit_v[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= RST_VAL;
      else        sp_q <= sp_d;
   end

   assign sp          = sp_q;
   assign stk_addr_lo = fit_v[1];
   assign stk_addr_hi = fit_v[2];

endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
   parameter int                SP_W     = 16,
   parameter int                IMPL_W   = 12,
   parameter logic [15:0]       RAM_END  = 16'h08FF,
   parameter int                IO_AW    = 6,
   parameter logic [IO_AW-1:0]  SPH_ADDR = 6'h3E,
   parameter logic [IO_AW-1:0]  SPL_ADDR = 6'h3D
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_byte,
   input logic             pop_byte,
   input logic             push_ret,
   input logic             pop_ret,
   input logic [IO_AW-1:0] io_addr,
   input logic             io_wr,
   input logic [7:0]       io_wdata,
   input logic [SP_W-1:0]  sp,
   input logic [SP_W-1:0]  stk_addr_lo,
   input logic [SP_W-1:0]  stk_addr_hi
);

   localparam logic [SP_W:0]   CK_TOP  = (SP_W+1)'(1) << IMPL_W;
   localparam logic [SP_W-1:0] CK_MASK = SP_W'(CK_TOP - 1'b1);
   localparam logic [SP_W-1:0] CK_RST  = SP_W'(RAM_END) & CK_MASK;

   logic hit_hi, hit_lo, hit_any, no_cmd;
   assign hit_hi  = io_wr && (io_addr == SPH_ADDR);
   assign hit_lo  = io_wr && (io_addr == SPL_ADDR);
   assign hit_any = hit_hi || hit_lo;
   assign no_cmd  = !(push_byte || pop_byte || push_ret || pop_ret);

   assert_reset_value_R1: assert property (@(posedge clk)
      !rst_n |=> sp == CK_RST);

   assert_push_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_byte && !push_ret && !pop_ret && !hit_any)
      |=> sp == (($past(sp) - SP_W'(1)) & CK_MASK));

   assert_pop_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_byte && !push_byte && !push_ret && !pop_ret && !hit_any)
      |=> sp == (($past(sp) + SP_W'(1)) & CK_MASK));

   assert_push_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ret && !hit_any) |=> sp == (($past(sp) - SP_W'(2)) & CK_MASK));

   assert_push_ret_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push_ret |-> (stk_addr_lo == sp) &&
                   (stk_addr_hi == ((sp - SP_W'(1)) & CK_MASK)));

   assert_pop_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ret && !push_ret && !hit_any)
      |=> sp == (($past(sp) + SP_W'(2)) & CK_MASK));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hi |=> sp[15:8] == ($past(io_wdata) & CK_MASK[15:8]) &&
                 sp[7:0]  == $past(sp[7:0]));

   assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((sp | stk_addr_lo | stk_addr_hi) & ~CK_MASK) == '0);

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && !hit_any) |=> $stable(sp));

endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
   .SP_W(SP_W), .IMPL_W(IMPL_W), .RAM_END(RAM_END),
   .IO_AW(IO_AW), .SPH_ADDR(SPH_ADDR), .SPL_ADDR(SPL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .push_byte(push_byte), .pop_byte(pop_byte),
   .push_ret(push_ret), .pop_ret(pop_ret),
   .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
   .sp(sp), .stk_addr_lo(stk_addr_lo), .stk_addr_hi(stk_addr_hi)
);

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;

   localparam int MSK = 'hFFF;
   localparam int TOP = 'h8FF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_byte = 0, pop_byte = 0, push_ret = 0, pop_ret = 0;
   logic [5:0] io_addr = 6'h00;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic [15:0] sp, stk_addr_lo, stk_addr_hi;

   int total = 0;
   int bad = 0;
   int ref_sp;
   bit done = 0;

   always #2 clk = ~clk;

   stack_ptr_unit u_stack_ptr_unit (
      .clk(clk), .rst_n(rst_n),
      .push_byte(push_byte), .pop_byte(pop_byte),
      .push_ret(push_ret), .pop_ret(pop_ret),
      .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .sp(sp),
      .stk_addr_lo(stk_addr_lo), .stk_addr_hi(stk_addr_hi)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One clock: drive at negedge, compare combinational outputs, then advance the model
   task automatic cyc(input bit p1, input bit o1, input bit p2, input bit o2,
                      input bit wr, input logic [5:0] a, input logic [7:0] d);
      int    nxt, lo, hi, cnt, rd;
      string tag;
      push_byte = p1; pop_byte = o1; push_ret = p2; pop_ret = o2;
      io_wr = wr; io_addr = a; io_wdata = d;
      #1;
      cnt = int'(p1) + int'(o1) + int'(p2) + int'(o2);
      if (p2)      begin nxt = ref_sp - 2; lo = ref_sp;     hi = ref_sp - 1; tag = "R4"; end
      else if (o2) begin nxt = ref_sp + 2; lo = ref_sp + 2; hi = ref_sp + 1; tag = "R5"; end
      else if (p1) begin nxt = ref_sp - 1; lo = ref_sp;     hi = ref_sp;     tag = "R2"; end
      else if (o1) begin nxt = ref_sp + 1; lo = ref_sp + 1; hi = ref_sp + 1; tag = "R3"; end
      else         begin nxt = ref_sp;     lo = ref_sp;     hi = ref_sp;     tag = "R11"; end
      if (cnt > 1) tag = "R10";
      if (lo < 0 || lo > MSK || hi < 0 || hi > MSK) tag = "R8";
      rd = (a == 6'h3E) ? (ref_sp >> 8) : (a == 6'h3D) ? (ref_sp & 'hFF) : 0;
      check("R6", "io_rdata", int'(io_rdata), rd);
      check(tag, "stk_addr_lo", int'(stk_addr_lo), lo & MSK);
      check(tag, "stk_addr_hi", int'(stk_addr_hi), hi & MSK);
      check(tag, "sp", int'(sp), ref_sp);
      if (wr && a == 6'h3E)      nxt = (int'(d) << 8) | (ref_sp & 'hFF);
      else if (wr && a == 6'h3D) nxt = (ref_sp & 'hFF00) | int'(d);
      @(posedge clk);
      ref_sp = nxt & MSK;
      @(negedge clk);
      if (wr && cnt > 0 && (a == 6'h3E || a == 6'h3D))
         check("R9", "sp after write with command", int'(sp), ref_sp);
      else if (wr)
         check("R7", "sp after io write", int'(sp), ref_sp);
   endtask

   initial begin
      int seed;
      ref_sp = TOP;
      repeat (3) @(negedge clk);
      check("R1", "sp in reset", int'(sp), TOP);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "sp after reset", int'(sp), TOP);
      io_addr = 6'h3E; #1 check("R6", "read high", int'(io_rdata), 'h08);
      io_addr = 6'h3D; #1 check("R6", "read low", int'(io_rdata), 'hFF);
      @(negedge clk);
      // R2 R3 R4 R5 basic moves
      cyc(1,0,0,0, 0,6'h00,8'h00);
      cyc(1,0,0,0, 0,6'h00,8'h00);
      cyc(0,1,0,0, 0,6'h00,8'h00);
      cyc(0,0,1,0, 0,6'h00,8'h00);
      cyc(0,0,0,1, 0,6'h00,8'h00);
      cyc(0,0,0,0, 0,6'h00,8'h00);                       // R11 idle
      // R7 writes, then walk down through zero (R8 wrap)
      cyc(0,0,0,0, 1,6'h3D,8'h05);
      cyc(0,0,0,0, 1,6'h3E,8'h00);
      cyc(0,0,1,0, 0,6'h00,8'h00);
      cyc(0,0,1,0, 0,6'h00,8'h00);
      cyc(1,0,0,0, 0,6'h00,8'h00);
      cyc(1,0,0,0, 0,6'h00,8'h00);
      cyc(0,0,1,0, 0,6'h00,8'h00);
      check("R8", "sp wrapped low", int'(sp), 'hFFD);
      cyc(0,0,0,1, 0,6'h00,8'h00);
      cyc(0,1,0,0, 0,6'h00,8'h00);
      check("R8", "sp wrapped back", int'(sp), 'h000);
      // R8 unimplemented high bits discarded
      cyc(0,0,0,0, 1,6'h3E,8'hFF);
      check("R8", "high byte masked", int'(sp), 'hF00);
      cyc(0,0,0,1, 0,6'h00,8'h00);
      // R7 write to another address ignored
      cyc(0,0,0,0, 1,6'h3F,8'h12);
      check("R7", "foreign write ignored", int'(sp), 'hF02);
      // R9 write in same cycle as commands
      cyc(1,0,0,0, 1,6'h3D,8'h40);
      check("R9", "low write beats push", int'(sp), 'hF40);
      cyc(0,0,0,1, 1,6'h3E,8'h03);
      check("R9", "high write beats pop", int'(sp), 'h340);
      // R10 priority among simultaneous commands
      cyc(1,1,1,1, 0,6'h00,8'h00);
      check("R10", "return push wins", int'(sp), 'h33E);
      cyc(1,1,0,1, 0,6'h00,8'h00);
      check("R10", "return pop wins", int'(sp), 'h340);
      cyc(1,1,0,0, 0,6'h00,8'h00);
      check("R10", "byte push wins", int'(sp), 'h33F);
      // Mixed random traffic against the model
      seed = 7;
      for (int i = 0; i < 400; i++) begin
         int r;
         seed = seed * 1103515245 + 12345;
         r = (seed >>> 8) & 'hFFFF;
         cyc(r[0] && r[4], r[1] && r[5], r[2] && r[6] && r[7], r[3] && r[6],
             r[8] && r[9], (r[10]) ? 6'h3E : (r[11] ? 6'h3D : 6'h21), r[15:8]);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule